// File: doc/BRIEF.md
# Load-Store Lane Aligner

This block sits between an integer core's execute stage and a data memory that is organised as full 32-bit words. Each request carries a base register value, a 12-bit signed offset, a store/load select, the three-bit width code from the instruction and, for stores, the source register value. The block forms the effective address. For a store it places the source bytes on the correct byte lanes and raises only the matching byte write enables. For a load it pulls the addressed byte or halfword out of the returned memory word and extends it to the full register width.

All results are registered together in a single pipeline stage, so a request presented in one cycle yields its address, write lanes, load value and alignment flag in the next. The memory word for a load is supplied in the same cycle as the request. Width codes that name no access produce no write lanes and a zero load value. A separate flag reports accesses that do not sit on their natural boundary. The block does not trap them; it still performs the lane placement described below.

Top module: `lsa_top`

## Requirements
- R1: `eff_addr` equals `base_addr` plus `offset_imm` sign-extended to 32 bits, modulo 2^32, one cycle after the request.
- R2: `rsp_valid` is `req_valid` delayed by one cycle, and a cycle with no request is followed by a zero `wr_mask`, `wr_data` and `ld_result`; all three are zero after reset.
- R3: A store with code 000 (byte) gives `wr_mask` = 0001 shifted left by address bits 1:0, and `wr_data` holds `store_src[7:0]` in that lane with all other bits zero.
- R4: A store with code 001 (halfword) gives `wr_mask` 0011 when address bit 1 is 0 and 1100 when it is 1, with `store_src[15:0]` in the chosen half and zeros elsewhere; address bit 0 does not move the lanes.
- R5: A store with code 010 (word) gives `wr_mask` 1111 and `wr_data` equal to `store_src`, whatever the low address bits are.
- R6: Loads with code 000 (signed byte, lane = address bits 1:0) and 001 (signed halfword, lane = address bit 1) return the selected field sign-extended to 32 bits.
- R7: Loads with code 100 (unsigned byte) and 101 (unsigned halfword) return the selected field zero-extended to 32 bits, with the same lane choice as R6.
- R8: A load with code 010 (word) returns `mem_rdata` unchanged, whatever the low address bits are.
- R9: `misaligned` is 1 exactly for a halfword access (store 001, load 001 or 101) with address bit 0 set, or a word access (code 010) with address bits 1:0 nonzero; it is 0 for bytes, for undefined codes and for idle cycles.
- R10: Undefined codes (store 011, 100, 101, 110, 111; load 011, 110, 111) give a zero `wr_mask`, zero `wr_data` and zero `ld_result`.
- R11: A load never raises any `wr_mask` bit and leaves `wr_data` zero; a store always returns a zero `ld_result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 for a store, 0 for a load |
| funct3 | input | 3 | Width and extension code of the access |
| base_addr | input | 32 | Base register value |
| offset_imm | input | 12 | Signed address offset |
| store_src | input | 32 | Source register value for stores |
| mem_rdata | input | 32 | Memory word read at the request's word address |
| rsp_valid | output | 1 | Registered result present |
| eff_addr | output | 32 | Effective byte address |
| wr_mask | output | 4 | Byte-lane write enables, bit n for bits 8n+7:8n |
| wr_data | output | 32 | Lane-placed store data |
| ld_result | output | 32 | Extracted and extended load value |
| misaligned | output | 1 | Access is off its natural boundary |

## Verification
Every result of this block is due exactly one clock edge after its request: the address, lanes, load value and flag all come from one register stage. The bench drives each request on a falling edge, lets one rising edge register it and reads every output on the following falling edge, before the next request can be clocked in. Idle checks are placed the same way, one falling edge after `req_valid` drops, so that the zeroed lanes and load value of R2 are seen at the exact cycle they are due.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    // Access width decoded from the width code
    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_HALF = 2'd2,
        SZ_WORD = 2'd3
    } lsa_size_e;

    typedef struct packed {
        lsa_size_e size;
        logic      sext;
    } lsa_access_t;

    // Width codes shared by loads and stores
    localparam logic [2:0] CODE_BYTE   = 3'b000;
    localparam logic [2:0] CODE_HALF   = 3'b001;
    localparam logic [2:0] CODE_WORD   = 3'b010;
    localparam logic [2:0] CODE_BYTE_U = 3'b100;
    localparam logic [2:0] CODE_HALF_U = 3'b101;

    function automatic lsa_access_t lsa_decode(input logic is_store,
                                               input logic [2:0] code);
        lsa_access_t acc;
        acc.size = SZ_NONE;
        acc.sext = 1'b0;
        if (is_store) begin
            unique case (code)
                CODE_BYTE: acc.size = SZ_BYTE;
                CODE_HALF: acc.size = SZ_HALF;
                CODE_WORD: acc.size = SZ_WORD;
                default:   acc.size = SZ_NONE;
            endcase
        end else begin
            unique case (code)
                CODE_BYTE:   begin acc.size = SZ_BYTE; acc.sext = 1'b1; end
                CODE_HALF:   begin acc.size = SZ_HALF; acc.sext = 1'b1; end
                CODE_WORD:   acc.size = SZ_WORD;
                CODE_BYTE_U: acc.size = SZ_BYTE;
                CODE_HALF_U: acc.size = SZ_HALF;
                default:     acc.size = SZ_NONE;
            endcase
        end
        return acc;
    endfunction

endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic [DATA_W-1:0] base,
    input  logic [IMM_W-1:0]  offset,
    output logic [DATA_W-1:0] addr
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] offset_ext;

    always_comb begin
        offset_ext = {{EXT_W{offset[IMM_W-1]}}, offset};
        addr       = base + offset_ext;
    end
endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  lsa_size_e                      size,
    input  logic [$clog2(DATA_W/8)-1:0]    off,
    input  logic [DATA_W-1:0]              src,
    output logic [DATA_W/8-1:0]            mask,
    output logic [DATA_W-1:0]              data
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    // One slice per byte lane
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic       en;
        logic [7:0] byte_val;

        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    en       = (off == OFF_W'(i));
                    byte_val = src[7:0];
                end
                SZ_HALF: begin
                    en       = (off[OFF_W-1:1] == (OFF_W-1)'(i / 2));
                    byte_val = src[8*(i%2) +: 8];
                end
                SZ_WORD: begin
                    en       = 1'b1;
                    byte_val = src[8*i +: 8];
                end
                default: begin
                    en       = 1'b0;
                    byte_val = 8'h00;
                end
            endcase
        end

        assign mask[i]         = en;
        assign data[8*i +: 8]  = en ? byte_val : 8'h00;
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  lsa_size_e                      size,
    input  logic                           sext,
    input  logic [$clog2(DATA_W/8)-1:0]    off,
    input  logic [DATA_W-1:0]              word,
    output logic [DATA_W-1:0]              result
);
    localparam int LANES  = DATA_W / 8;
    localparam int HALVES = LANES / 2;
    localparam int OFF_W  = $clog2(LANES);

    logic [7:0]  bytes  [LANES];
    logic [15:0] halves [HALVES];

    for (genvar i = 0; i < LANES; i++) begin : g_byte
        assign bytes[i] = word[8*i +: 8];
    end
    for (genvar j = 0; j < HALVES; j++) begin : g_half
        assign halves[j] = word[16*j +: 16];
    end

    logic [7:0]  sel_b;
    logic [15:0] sel_h;
    logic        fill_b;
    logic        fill_h;

    always_comb begin
        sel_b  = bytes[off];
        sel_h  = halves[off[OFF_W-1:1]];
        fill_b = sext & sel_b[7];
        fill_h = sext & sel_h[15];
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){fill_b}}, sel_b};
            SZ_HALF: result = {{(DATA_W-16){fill_h}}, sel_h};
            SZ_WORD: result = word;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/lsa_top.sv
module lsa_top
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_is_store,
    input  logic [2:0]           funct3,
    input  logic [DATA_W-1:0]    base_addr,
    input  logic [IMM_W-1:0]     offset_imm,
    input  logic [DATA_W-1:0]    store_src,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    eff_addr,
    output logic [DATA_W/8-1:0]  wr_mask,
    output logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    ld_result,
    output logic                 misaligned
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] addr;
        logic [LANES-1:0]  mask;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              misal;
    } stage_t;

    stage_t stage_d;
    stage_t stage_q;

    logic [DATA_W-1:0] addr_w;
    lsa_access_t       acc_w;
    logic [OFF_W-1:0]  off_w;
    logic [LANES-1:0]  lane_mask_w;
    logic [DATA_W-1:0] lane_data_w;
    logic [DATA_W-1:0] load_val_w;

    lsa_addr_gen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_addr (
        .base   (base_addr),
        .offset (offset_imm),
        .addr   (addr_w)
    );

    assign acc_w = lsa_decode(req_is_store, funct3);
    assign off_w = addr_w[OFF_W-1:0];

    lsa_store_lane #(.DATA_W(DATA_W)) u_store (
        .size (acc_w.size),
        .off  (off_w),
        .src  (store_src),
        .mask (lane_mask_w),
        .data (lane_data_w)
    );

    lsa_load_extract #(.DATA_W(DATA_W)) u_load (
        .size   (acc_w.size),
        .sext   (acc_w.sext),
        .off    (off_w),
        .word   (mem_rdata),
        .result (load_val_w)
    );

    // Next-state computation
    always_comb begin
        stage_d       = '0;
        stage_d.valid = req_valid;
        stage_d.addr  = addr_w;
        if (req_valid) begin
            if (req_is_store) begin
                stage_d.mask  = lane_mask_w;
                stage_d.wdata = lane_data_w;
            end else begin
                stage_d.rdata = load_val_w;
            end
            unique case (acc_w.size)
                SZ_HALF: stage_d.misal = off_w[0];
                SZ_WORD: stage_d.misal = (off_w != '0);
                default: stage_d.misal = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign rsp_valid  = stage_q.valid;
    assign eff_addr   = stage_q.addr;
    assign wr_mask    = stage_q.mask;
    assign wr_data    = stage_q.wdata;
    assign ld_result  = stage_q.rdata;
    assign misaligned = stage_q.misal;
endmodule

// File: rtl/lsa_top_chk.sv
module lsa_top_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_is_store,
    input logic [2:0]          funct3,
    input logic [DATA_W-1:0]   store_src,
    input logic                rsp_valid,
    input logic [DATA_W/8-1:0] wr_mask,
    input logic [DATA_W-1:0]   wr_data,
    input logic [DATA_W-1:0]   ld_result,
    input logic                misaligned
);
    localparam int LANES = DATA_W / 8;

    function automatic logic [DATA_W-1:0] lanes_to_bits(input logic [LANES-1:0] m);
        logic [DATA_W-1:0] b;
        for (int i = 0; i < LANES; i++) begin
            b[8*i +: 8] = {8{m[i]}};
        end
        return b;
    endfunction

    assert_resp_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (wr_mask == '0 && wr_data == '0 && ld_result == '0));

    assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_is_store && funct3 == 3'b000) |-> $countones(wr_mask) == 1);

    assert_data_in_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data & ~lanes_to_bits(wr_mask)) == '0);

    assert_half_two_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_is_store && funct3 == 3'b001) |-> $countones(wr_mask) == 2);

    assert_word_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_is_store && funct3 == 3'b010)
        |-> (wr_mask == '1 && wr_data == $past(store_src)));

    assert_ubyte_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_is_store && funct3 == 3'b100) |-> ld_result[DATA_W-1:8] == '0);

    assert_flag_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> rsp_valid);

    assert_undef_load_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_is_store && (funct3 == 3'b011 || funct3[2:1] == 2'b11))
        |-> (ld_result == '0 && !misaligned));

    assert_load_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_is_store) |-> (wr_mask == '0 && wr_data == '0));

    assert_store_no_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_is_store) |-> ld_result == '0);
endmodule

bind lsa_top lsa_top_chk #(.DATA_W(DATA_W)) u_lsa_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_is_store (req_is_store),
    .funct3       (funct3),
    .store_src    (store_src),
    .rsp_valid    (rsp_valid),
    .wr_mask      (wr_mask),
    .wr_data      (wr_data),
    .ld_result    (ld_result),
    .misaligned   (misaligned)
);

// File: tb/lsa_top_test.sv
`timescale 1ns/1ps
module lsa_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_store = 1'b0;
    logic [2:0]  funct3 = 3'b000;
    logic [31:0] base_addr = '0;
    logic [11:0] offset_imm = '0;
    logic [31:0] store_src = '0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [31:0] eff_addr;
    logic [3:0]  wr_mask;
    logic [31:0] wr_data;
    logic [31:0] ld_result;
    logic        misaligned;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lsa_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_is_store (req_is_store),
        .funct3       (funct3),
        .base_addr    (base_addr),
        .offset_imm   (offset_imm),
        .store_src    (store_src),
        .mem_rdata    (mem_rdata),
        .rsp_valid    (rsp_valid),
        .eff_addr     (eff_addr),
        .wr_mask      (wr_mask),
        .wr_data      (wr_data),
        .ld_result    (ld_result),
        .misaligned   (misaligned)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Expected-value model written from the requirements
    function automatic logic [3:0] m_mask(input bit st, input logic [2:0] f, input logic [1:0] a);
        if (!st) return 4'b0000;
        case (f)
            3'b000: return 4'b0001 << a;
            3'b001: return a[1] ? 4'b1100 : 4'b0011;
            3'b010: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] m_wdata(input bit st, input logic [2:0] f,
                                            input logic [1:0] a, input logic [31:0] s);
        if (!st) return 32'h0;
        case (f)
            3'b000: return {24'h0, s[7:0]} << (8 * a);
            3'b001: return {16'h0, s[15:0]} << (a[1] ? 16 : 0);
            3'b010: return s;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] m_load(input bit st, input logic [2:0] f,
                                           input logic [1:0] a, input logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        b = 8'((w >> (8 * a)) & 32'hff);
        h = a[1] ? w[31:16] : w[15:0];
        if (st) return 32'h0;
        case (f)
            3'b000: return {{24{b[7]}}, b};
            3'b001: return {{16{h[15]}}, h};
            3'b010: return w;
            3'b100: return {24'h0, b};
            3'b101: return {16'h0, h};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_misal(input bit st, input logic [2:0] f, input logic [1:0] a);
        bit half;
        half = (f == 3'b001) || (!st && f == 3'b101);
        if (half) return a[0];
        if (f == 3'b010) return a != 2'b00;
        return 1'b0;
    endfunction

    function automatic string tag_wr(input bit st, input logic [2:0] f);
        if (!st) return "R11";
        case (f)
            3'b000: return "R3";
            3'b001: return "R4";
            3'b010: return "R5";
            default: return "R10";
        endcase
    endfunction

    function automatic string tag_rd(input bit st, input logic [2:0] f);
        if (st) return "R11";
        case (f)
            3'b000, 3'b001: return "R6";
            3'b100, 3'b101: return "R7";
            3'b010: return "R8";
            default: return "R10";
        endcase
    endfunction

    // Drive at a falling edge; results are due after the next rising edge
    task automatic run_req(input bit st, input logic [2:0] f, input logic [31:0] b,
                           input logic [11:0] imm, input logic [31:0] s, input logic [31:0] w);
        logic [31:0] ea;
        ea           = b + {{20{imm[11]}}, imm};
        req_valid    = 1'b1;
        req_is_store = st;
        funct3       = f;
        base_addr    = b;
        offset_imm   = imm;
        store_src    = s;
        mem_rdata    = w;
        @(negedge clk);
        chk("R2", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk("R1", "eff_addr", eff_addr, ea);
        chk(tag_wr(st, f), "wr_mask", 32'(wr_mask), 32'(m_mask(st, f, ea[1:0])));
        chk(tag_wr(st, f), "wr_data", wr_data, m_wdata(st, f, ea[1:0], s));
        chk(tag_rd(st, f), "ld_result", ld_result, m_load(st, f, ea[1:0], w));
        chk("R9", "misaligned", 32'(misaligned), 32'(m_misal(st, f, ea[1:0])));
    endtask

    task automatic run_idle();
        req_valid    = 1'b0;
        req_is_store = 1'b1;
        funct3       = 3'b010;
        store_src    = 32'hdead_beef;
        mem_rdata    = 32'hffff_ffff;
        @(negedge clk);
        chk("R2", "idle rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R2", "idle wr_mask", 32'(wr_mask), 32'd0);
        chk("R2", "idle wr_data", wr_data, 32'd0);
        chk("R2", "idle ld_result", ld_result, 32'd0);
        chk("R9", "idle misaligned", 32'(misaligned), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2", "reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R2", "reset wr_mask", 32'(wr_mask), 32'd0);
        chk("R2", "reset ld_result", ld_result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: negative offset and wraparound
        run_req(1'b0, 3'b010, 32'h0000_1000, 12'hffc, 32'h0, 32'h1234_5678);
        run_req(1'b0, 3'b010, 32'hffff_ffff, 12'h001, 32'h0, 32'hcafe_f00d);
        run_req(1'b1, 3'b000, 32'h1111_4444, 12'h7ff, 32'ha5a5_a5a5, 32'h0);

        // R3 byte stores, every lane; R4 halfword stores, every offset
        for (int a = 0; a < 4; a++) begin
            run_req(1'b1, 3'b000, 32'h2000, 12'(a), 32'h1234_56c3, 32'h0);
            run_req(1'b1, 3'b001, 32'h2000, 12'(a), 32'h89ab_cdef, 32'h0);
            run_req(1'b1, 3'b010, 32'h2000, 12'(a), 32'h89ab_cdef, 32'h0);  // R5
        end

        // R6/R7/R8 loads at every offset, sign bits set
        for (int a = 0; a < 4; a++) begin
            run_req(1'b0, 3'b000, 32'h3000, 12'(a), 32'h0, 32'h80ff_7f81);
            run_req(1'b0, 3'b100, 32'h3000, 12'(a), 32'h0, 32'h80ff_7f81);
            run_req(1'b0, 3'b001, 32'h3000, 12'(a), 32'h0, 32'h8001_7ffe);
            run_req(1'b0, 3'b101, 32'h3000, 12'(a), 32'h0, 32'h8001_7ffe);
            run_req(1'b0, 3'b010, 32'h3000, 12'(a), 32'h0, 32'h8001_7ffe);
        end

        // R10: undefined codes for stores and loads
        for (int f = 3; f < 8; f++) begin
            run_req(1'b1, 3'(f), 32'h4000, 12'h2, 32'hffff_ffff, 32'hffff_ffff);
            if (f == 3 || f >= 6)
                run_req(1'b0, 3'(f), 32'h4001, 12'h0, 32'hffff_ffff, 32'hffff_ffff);
        end

        run_idle();

        // Constrained random mix, occasional idle cycles
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 9) == 0) begin
                run_idle();
            end else begin
                run_req(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
                        $urandom(), 12'($urandom()), $urandom(), $urandom());
            end
        end
        run_idle();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule